// File: doc/BRIEF.md
# Coherent Position Snapshot Reader

This block connects a free-running 16-bit position count to an 8-bit host read port. A snapshot register follows the count on every rising clock edge while the host is idle. Once the host starts a read, the snapshot is frozen. It stays frozen until the read sequence ends, so the two bytes the host collects always come from one and the same count value. The counter itself keeps running the whole time and loses no counts; only the copy into the snapshot pauses.

The host controls the port with an active-low read enable and a byte-select pin. The block samples both on the falling clock edge, and the host must drive them synchronously to the clock. The data pins and their drive enable follow the read-enable and select pins combinationally, so a pad ring can turn them into a tri-state bus. A two-bit width setting chooses how the upper byte is presented:
- full 16-bit value,
- 12-bit value, with the top nibble of the upper byte zero,
- 8-bit value, with the upper byte zero.

The freeze is released only after a low-byte access has been seen and the read enable has returned high. Reading only the upper byte therefore keeps the snapshot frozen until a low-byte read completes.

Top module: `poslatch_reader`

## Requirements
- R1: While no read is active and no freeze is pending, the snapshot loads `count_in` on every rising edge. The host sees the value present before edge N from edge N onward.
- R2: When `rd_oe_n` is sampled low, the snapshot stops loading. It stays unchanged through every later sampled-high gap until the release of R5, even while `count_in` keeps changing.
- R3: `bus_doe` is 1 exactly while `rd_oe_n` is 0. While `bus_doe` is 0, `bus_dout` is 8'h00.
- R4: In 16-bit mode (`read_mode` 2'b10 or 2'b11), `byte_sel` = 0 presents snapshot bits 15:8 and `byte_sel` = 1 presents bits 7:0.
- R5: A read with `byte_sel` sampled 1 marks the low byte as taken. Loading resumes one edge after the next rising edge at which `rd_oe_n` is sampled high. An upper-byte-only read never releases the freeze.
- R6: If a read starts in the clock cycle in which the count rolls over from FFFFh to 0000h, both bytes of that read return FFh.
- R7: In 12-bit mode (`read_mode` 2'b01), the upper byte is {4'b0000, snapshot bits 11:8}, and the lower byte is unchanged.
- R8: In 8-bit mode (`read_mode` 2'b00), the upper byte reads 8'h00, and the lower byte is snapshot bits 7:0.
- R9: `rd_oe_n` and `byte_sel` are sampled only on the falling edge. A low pulse on `rd_oe_n` that covers no falling edge does not freeze the snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; control pins are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_in | input | 16 | Running position count to be captured |
| read_mode | input | 2 | 00: 8-bit, 01: 12-bit, 10/11: 16-bit presentation |
| rd_oe_n | input | 1 | Active-low read enable from the host |
| byte_sel | input | 1 | 0 selects the upper byte, 1 selects the lower byte |
| bus_dout | output | 8 | Byte presented to the host data pins |
| bus_doe | output | 1 | Drive enable for the data pins (1 = drive, 0 = high impedance) |

## Verification
A freeze flag that is stuck set shows up at the next read as a stale byte after the release point. A freeze flag that fails to set shows up as the two halves of one read coming from different count values as soon as the count moves between the byte accesses. A wrong release condition appears on the first upper-byte-only read followed by a fresh read. A sampling edge that is wrong shows up as a short read-enable pulse freezing the snapshot, visible on the following read. Width masking and byte ordering errors appear combinationally on the very byte being read.

// File: rtl/pl_pkg.sv
package pl_pkg;

   typedef enum logic [1:0] {
      RD_W8      = 2'b00,
      RD_W12     = 2'b01,
      RD_W16     = 2'b10,
      RD_W16_ALT = 2'b11
   } rd_width_e;

   function automatic logic is_full_width(rd_width_e m);
      return (m == RD_W16) || (m == RD_W16_ALT);
   endfunction

endpackage

// File: rtl/pl_edge_sampler.sv
// Falling-edge capture of the host control pins.
module pl_edge_sampler #(
   parameter int unsigned NUM_PINS = 2,
   parameter logic [NUM_PINS-1:0] IDLE_VAL = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_in,
   output logic [NUM_PINS-1:0] pins_q
);

   generate
      if (NUM_PINS == 0) begin : g_bad
         $error("pl_edge_sampler: NUM_PINS must be nonzero");
      end
   endgenerate

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) pins_q <= IDLE_VAL;
      else        pins_q <= pins_in;
   end

endmodule

// File: rtl/pl_inhibit_ctrl.sv
// Freeze state: set by any sampled read, cleared after a low-byte access ends.
module pl_inhibit_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_act,
   input  logic lo_sel,
   output logic hold_o,
   output logic load_o
);

   logic hold_q;
   logic lo_taken_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= 1'b0;
         lo_taken_q <= 1'b0;
      end else if (rd_act) begin
         hold_q <= 1'b1;
         if (lo_sel) lo_taken_q <= 1'b1;
      end else if (lo_taken_q) begin
         hold_q     <= 1'b0;
         lo_taken_q <= 1'b0;
      end
   end

   assign hold_o = hold_q;
   assign load_o = !rd_act && !hold_q;

   // R2: a sampled read always arms the freeze
   p_set_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_act |=> hold_q);

   // R5: an upper-byte-only sequence keeps the freeze across idle gaps
   p_keep_without_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !rd_act && !lo_taken_q) |=> hold_q);

   // R5: a finished low-byte access releases the freeze
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_act && lo_taken_q) |=> !hold_q);

endmodule

// File: rtl/pl_pos_latch.sv
// Snapshot register of the running count.
module pl_pos_latch #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] d,
   output logic [CNT_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // R1: while loading, the snapshot follows the count one edge later
   p_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(d)));

   // R2: no load means the snapshot is untouched
   p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/pl_byte_mux.sv
// Width masking, byte selection and drive control toward the host pins.
module pl_byte_mux
   import pl_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BUS_W = 8,
   parameter int unsigned MID_W = 12
) (
   input  rd_width_e        mode,
   input  logic [CNT_W-1:0] snap,
   input  logic             sel_lo,
   input  logic             oe_n,
   output logic [BUS_W-1:0] dout,
   output logic             doe
);

   localparam int unsigned NUM_LANES = CNT_W / BUS_W;

   logic [CNT_W-1:0] keep_mask;
   logic [CNT_W-1:0] shown;
   logic [BUS_W-1:0] lane [NUM_LANES];
   logic [BUS_W-1:0] picked;

   generate
      for (genvar b = 0; b < CNT_W; b++) begin : g_mask
         if (b < BUS_W) begin : g_low
            assign keep_mask[b] = 1'b1;
         end else if (b < MID_W) begin : g_mid
            assign keep_mask[b] = (mode != RD_W8);
         end else begin : g_top
            assign keep_mask[b] = is_full_width(mode);
         end
      end
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         assign lane[l] = shown[l*BUS_W +: BUS_W];
      end
   endgenerate

   assign shown  = snap & keep_mask;
   assign picked = sel_lo ? lane[0] : lane[NUM_LANES-1];
   assign doe    = !oe_n;
   assign dout   = oe_n ? '0 : picked;

   always_comb begin
      // R8: in 8-bit mode the upper lane is empty
      if (mode == RD_W8) begin
         p_upper_empty_r8: assert (lane[NUM_LANES-1] == '0);
      end
      // R7: in 12-bit mode only the low nibble of the upper lane survives
      if (mode == RD_W12) begin
         p_upper_nibble_r7: assert (shown[CNT_W-1:MID_W] == '0);
      end
      // R3: nothing leaves the block while the pins are released
      if (oe_n) begin
         p_quiet_bus_r3: assert (dout == '0);
      end
   end

endmodule

// File: rtl/poslatch_reader.sv
module poslatch_reader
   import pl_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned BUS_W = 8,
   parameter int unsigned MID_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_in,
   input  logic [1:0]       read_mode,
   input  logic             rd_oe_n,
   input  logic             byte_sel,
   output logic [BUS_W-1:0] bus_dout,
   output logic             bus_doe
);

   localparam int unsigned NUM_CTRL = 2;
   localparam logic [NUM_CTRL-1:0] CTRL_IDLE = 2'b01; // {sel, oe_n}

   generate
      if (CNT_W != 2 * BUS_W) begin : g_chk_w
         $error("poslatch_reader: CNT_W must be twice BUS_W");
      end
      if (MID_W <= BUS_W || MID_W >= CNT_W) begin : g_chk_mid
         $error("poslatch_reader: MID_W must lie strictly between BUS_W and CNT_W");
      end
   endgenerate

   logic [NUM_CTRL-1:0] ctrl_q;
   logic                oe_n_q;
   logic                sel_q;
   logic                hold;
   logic                load;
   logic [CNT_W-1:0]    snap;

   pl_edge_sampler #(
      .NUM_PINS (NUM_CTRL),
      .IDLE_VAL (CTRL_IDLE)
   ) u_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_in ({byte_sel, rd_oe_n}),
      .pins_q  (ctrl_q)
   );

   assign oe_n_q = ctrl_q[0];
   assign sel_q  = ctrl_q[1];

   pl_inhibit_ctrl u_inhibit (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_act (!oe_n_q),
      .lo_sel (sel_q),
      .hold_o (hold),
      .load_o (load)
   );

   pl_pos_latch #(
      .CNT_W (CNT_W)
   ) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .d     (count_in),
      .q     (snap)
   );

   pl_byte_mux #(
      .CNT_W (CNT_W),
      .BUS_W (BUS_W),
      .MID_W (MID_W)
   ) u_mux (
      .mode   (rd_width_e'(read_mode)),
      .snap   (snap),
      .sel_lo (byte_sel),
      .oe_n   (rd_oe_n),
      .dout   (bus_dout),
      .doe    (bus_doe)
   );

   // R9: a read recognised on a rising edge was seen on the preceding falling edge
   p_sampled_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n_q |=> hold);

endmodule

// File: tb/poslatch_reader_tb.sv
`timescale 1ns/1ps
module poslatch_reader_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] count_in = '0;
   logic [1:0]  read_mode = 2'b10;
   logic        rd_oe_n = 1'b1;
   logic        byte_sel = 1'b0;
   logic [7:0]  bus_dout;
   logic        bus_doe;
   logic        run = 1'b0;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   poslatch_reader u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .count_in  (count_in),
      .read_mode (read_mode),
      .rd_oe_n   (rd_oe_n),
      .byte_sel  (byte_sel),
      .bus_dout  (bus_dout),
      .bus_doe   (bus_doe)
   );

   // free-running count, stepped just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (run) count_in = count_in + 16'd1;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic read_byte(input logic lo, output logic [7:0] v, output logic en);
      @(posedge clk); #2;
      byte_sel = lo;
      rd_oe_n  = 1'b0;
      @(negedge clk); #2;
      v  = bus_dout;
      en = bus_doe;
      @(posedge clk); #2;
      rd_oe_n = 1'b1;
   endtask

   task automatic set_count(input logic [15:0] v);
      @(posedge clk); #2;
      count_in = v;
      repeat (3) @(posedge clk);
   endtask

   task automatic t_reset;
      chk("R3 reset doe", {15'd0, bus_doe}, 16'd0);
      chk("R3 reset dout", {8'd0, bus_dout}, 16'd0);
   endtask

   task automatic t_track_and_freeze;
      logic [7:0] v; logic en;
      read_mode = 2'b10;
      set_count(16'h1234);
      read_byte(1'b0, v, en);
      chk("R4 upper byte", {8'd0, v}, 16'h0012);
      chk("R3 doe during read", {15'd0, en}, 16'd1);
      @(posedge clk); #1;
      chk("R3 doe released", {15'd0, bus_doe}, 16'd0);
      chk("R3 dout released", {8'd0, bus_dout}, 16'd0);
      count_in = 16'h5678;
      read_byte(1'b1, v, en);
      chk("R2 lower byte frozen", {8'd0, v}, 16'h0034);
      repeat (3) @(posedge clk);
      read_byte(1'b0, v, en);
      chk("R1 new upper byte", {8'd0, v}, 16'h0056);
      read_byte(1'b1, v, en);
      chk("R1 new lower byte", {8'd0, v}, 16'h0078);
      repeat (3) @(posedge clk);
   endtask

   task automatic t_running_coherent;
      logic [7:0] hi, lo; logic en; logic [15:0] snap;
      read_mode = 2'b11;
      set_count(16'h20F0);
      run = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      snap = count_in;
      read_byte(1'b0, hi, en);
      read_byte(1'b1, lo, en);
      chk("R2 coherent read while counting", {hi, lo}, snap);
      chk("R2 counter kept running", {15'd0, count_in != snap}, 16'd1);
      run = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   task automatic t_upper_only;
      logic [7:0] v; logic en;
      read_mode = 2'b10;
      set_count(16'h1111);
      read_byte(1'b0, v, en);
      chk("R4 upper byte 11", {8'd0, v}, 16'h0011);
      count_in = 16'h2222;
      repeat (4) @(posedge clk);
      read_byte(1'b0, v, en);
      chk("R5 upper-only read keeps freeze", {8'd0, v}, 16'h0011);
      read_byte(1'b1, v, en);
      chk("R5 lower byte still frozen", {8'd0, v}, 16'h0011);
      repeat (3) @(posedge clk);
      read_byte(1'b0, v, en);
      chk("R5 released after low byte", {8'd0, v}, 16'h0022);
      read_byte(1'b1, v, en);
      repeat (3) @(posedge clk);
   endtask

   task automatic t_rollover;
      logic [7:0] hi, lo; logic en;
      read_mode = 2'b10;
      set_count(16'hFFFF);
      @(negedge clk);
      run = 1'b1;
      read_byte(1'b0, hi, en);
      read_byte(1'b1, lo, en);
      run = 1'b0;
      chk("R6 read at rollover", {hi, lo}, 16'hFFFF);
      repeat (3) @(posedge clk);
   endtask

   task automatic t_widths;
      logic [7:0] v; logic en;
      set_count(16'hABCD);
      read_mode = 2'b01;
      read_byte(1'b0, v, en);
      chk("R7 12-bit upper byte", {8'd0, v}, 16'h000B);
      read_byte(1'b1, v, en);
      chk("R7 12-bit lower byte", {8'd0, v}, 16'h00CD);
      repeat (3) @(posedge clk);
      read_mode = 2'b00;
      read_byte(1'b0, v, en);
      chk("R8 8-bit upper byte", {8'd0, v}, 16'h0000);
      read_byte(1'b1, v, en);
      chk("R8 8-bit lower byte", {8'd0, v}, 16'h00CD);
      repeat (3) @(posedge clk);
      read_mode = 2'b10;
   endtask

   task automatic t_short_pulse;
      logic [7:0] v; logic en;
      read_mode = 2'b10;
      set_count(16'h3333);
      @(posedge clk); #2;
      count_in = 16'h4444;
      #3 rd_oe_n = 1'b0;
      #1;
      chk("R3 drive follows pin", {15'd0, bus_doe}, 16'd1);
      #1 rd_oe_n = 1'b1;
      repeat (2) @(posedge clk);
      read_byte(1'b0, v, en);
      chk("R9 pulse between falling edges ignored", {8'd0, v}, 16'h0044);
      read_byte(1'b1, v, en);
      chk("R9 lower byte after pulse", {8'd0, v}, 16'h0044);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      t_track_and_freeze();
      t_running_coherent();
      t_upper_only();
      t_rollover();
      t_widths();
      t_short_pulse();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule